// File: doc/BRIEF.md
# Source Operand Address Sequencer

This block obtains the source operand of a word-sized move for a 16-bit processor with eight general registers, the last of which serves as the program counter. A 6-bit specifier selects the operand: the upper three bits give the addressing mode and the lower three bits give the register. After a start strobe, the block walks through the register-file accesses and memory reads that the mode calls for. It applies any increment or decrement to the register. When it has the operand, it presents it together with a one-cycle done pulse.

The register file lives outside the block. It is reached through one combinational read port and one write port that is written on the clock edge. Memory is reached through a word read port with request and acknowledge. The block holds the request and the address steady until the acknowledge arrives, so any memory latency works. The program counter needs no special path. Immediate, absolute, relative and relative-deferred forms follow from the general modes, because the program counter already points past the current instruction word. In the indexed modes the displacement fetch advances the program counter before the base register is read.

Top module: `src_opnd_seq`

## Requirements
- R1: Mode 0 (specifier bits [5:3] = 0) returns the contents of the named register, issues no memory read and writes no register. With register 7 the result is the program counter value.
- R2: Mode 1 returns the memory word at the address held in the register and leaves the register unchanged.
- R3: Mode 2 reads the word at the register's address and then writes the register back increased by 2. With register 7 this returns the next instruction word (immediate).
- R4: Mode 4 first lowers the register by 2, then returns the word at the lowered address.
- R5: Mode 3 reads a pointer at the register's address, raises the register by 2, and returns the word the pointer addresses. With register 7 the next instruction word is used as an absolute address.
- R6: Mode 5 lowers the register by 2, reads a pointer at the new address, and returns the word the pointer addresses.
- R7: Mode 6 reads a displacement at the program counter and raises the program counter by 2. It then returns the word at the register plus the displacement. With register 7 the raised program counter is used as the base.
- R8: Mode 7 behaves like mode 6 but treats the word at the sum as a pointer and returns the word that pointer addresses.
- R9: Each fetch writes at most one register. Modes 2 to 5 write only the named register, modes 6 and 7 write only register 7, and no write happens while idle.
- R10: The memory request and address stay constant from the cycle the request is raised until the cycle the acknowledge is seen, whatever the latency.
- R11: All address and register arithmetic wraps modulo 2^16 (0x0000 minus 2 gives 0xFFFE, and 0xFFFE plus 2 gives 0x0000).
- R12: A start strobe while a fetch is busy is ignored. The running fetch completes unchanged and no second fetch follows.
- R13: After reset, busy, done, memory request and register write are all low. Done is high for exactly one cycle per fetch, and the operand output is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| spec_i | input | 6 | Operand specifier: [5:3] mode, [2:0] register |
| rf_raddr_o | output | 3 | Register file read address |
| rf_rdata_i | input | 16 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register file write address |
| rf_wdata_o | output | 16 | Register file write data |
| mem_req_o | output | 1 | Memory word read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_ack_i | input | 1 | Memory acknowledge, read data valid |
| mem_rdata_i | input | 16 | Memory read data |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| opnd_o | output | 16 | Fetched source operand |

## Verification
The bench builds the block with its default parameters: a 16-bit data path and eight registers. With these values register 7 is the program counter, so the immediate, absolute, relative and relative-deferred forms fall out of the register-7 vectors. A 16-bit width also puts the wrap points at 0x0000 and 0xFFFE, where a narrower or wider data path would not. Memory latency varies across the vectors from zero to four wait cycles, so the request-holding behaviour is exercised in every fetch state.

// File: rtl/sos_pkg.sv
package sos_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REG,
    ST_PTR,
    ST_FDISP,
    ST_INDEX,
    ST_FPTR,
    ST_FOPND
  } sos_state_e;

  localparam logic [MODE_W-1:0] M_REG   = 3'd0;
  localparam logic [MODE_W-1:0] M_DEF   = 3'd1;
  localparam logic [MODE_W-1:0] M_AINC  = 3'd2;
  localparam logic [MODE_W-1:0] M_AINCD = 3'd3;
  localparam logic [MODE_W-1:0] M_ADEC  = 3'd4;
  localparam logic [MODE_W-1:0] M_ADECD = 3'd5;
  localparam logic [MODE_W-1:0] M_IDX   = 3'd6;
  localparam logic [MODE_W-1:0] M_IDXD  = 3'd7;
endpackage

// File: rtl/sos_ctrl.sv
module sos_ctrl
  import sos_pkg::*;
(
  input  sos_state_e              state_q,
  input  logic                    start_i,
  input  logic [MODE_W-1:0]       new_mode_i,
  input  logic [MODE_W-1:0]       mode_q,
  input  logic                    ack_i,
  output sos_state_e              state_d
);
  logic deferred;
  logic indexed;

  assign deferred = (mode_q == M_AINCD) || (mode_q == M_ADECD);
  assign indexed  = (mode_q == M_IDX) || (mode_q == M_IDXD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = (new_mode_i == M_REG) ? ST_REG : ST_PTR;
        end
      end
      ST_REG:   state_d = ST_IDLE;
      ST_PTR: begin
        if (indexed)       state_d = ST_FDISP;
        else if (deferred) state_d = ST_FPTR;
        else               state_d = ST_FOPND;
      end
      ST_FDISP: if (ack_i) state_d = ST_INDEX;
      ST_INDEX: state_d = (mode_q == M_IDXD) ? ST_FPTR : ST_FOPND;
      ST_FPTR:  if (ack_i) state_d = ST_FOPND;
      ST_FOPND: if (ack_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/sos_ptr_upd.sv
module sos_ptr_upd
  import sos_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DW-1:0]     base_i,
  output logic [DW-1:0]     addr_o,
  output logic [DW-1:0]     wval_o,
  output logic              we_o
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  always_comb begin
    addr_o = base_i;
    wval_o = base_i;
    we_o   = 1'b0;
    unique case (mode_i)
      M_AINC, M_AINCD, M_IDX, M_IDXD: begin
        wval_o = base_i + STEP;
        we_o   = 1'b1;
      end
      M_ADEC, M_ADECD: begin
        addr_o = base_i - STEP;
        wval_o = base_i - STEP;
        we_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/src_opnd_seq.sv
module src_opnd_seq
  import sos_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [MODE_W+$clog2(NREG)-1:0] spec_i,
  output logic [$clog2(NREG)-1:0]       rf_raddr_o,
  input  logic [DW-1:0]                 rf_rdata_i,
  output logic                          rf_we_o,
  output logic [$clog2(NREG)-1:0]       rf_waddr_o,
  output logic [DW-1:0]                 rf_wdata_o,
  output logic                          mem_req_o,
  output logic [DW-1:0]                 mem_addr_o,
  input  logic                          mem_ack_i,
  input  logic [DW-1:0]                 mem_rdata_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [DW-1:0]                 opnd_o
);
  localparam int RW = $clog2(NREG);
  localparam logic [RW-1:0] PC_IDX = RW'(NREG - 1);

  sos_state_e        state_q, state_d;
  logic [MODE_W-1:0] mode_q;
  logic [RW-1:0]     rn_q;
  logic [DW-1:0]     addr_q, addr_d;
  logic [DW-1:0]     disp_q;
  logic [DW-1:0]     opnd_q, opnd_d;
  logic              done_q, done_d;

  logic              accept;
  logic              addr_en, disp_en, opnd_en;
  logic [DW-1:0]     upd_addr, upd_wval;
  logic              upd_we;
  logic              fetch_pc;

  sos_ctrl u_ctrl (
    .state_q    (state_q),
    .start_i    (start_i),
    .new_mode_i (spec_i[RW +: MODE_W]),
    .mode_q     (mode_q),
    .ack_i      (mem_ack_i),
    .state_d    (state_d)
  );

  sos_ptr_upd #(.DW(DW)) u_upd (
    .mode_i (mode_q),
    .base_i (rf_rdata_i),
    .addr_o (upd_addr),
    .wval_o (upd_wval),
    .we_o   (upd_we)
  );

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign fetch_pc = (state_q == ST_PTR) && ((mode_q == M_IDX) || (mode_q == M_IDXD));

  assign rf_raddr_o = fetch_pc ? PC_IDX : rn_q;
  assign rf_we_o    = (state_q == ST_PTR) && upd_we;
  assign rf_waddr_o = rf_raddr_o;
  assign rf_wdata_o = upd_wval;

  assign mem_req_o  = (state_q == ST_FDISP) || (state_q == ST_FPTR) || (state_q == ST_FOPND);
  assign mem_addr_o = addr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign opnd_o     = opnd_q;

  always_comb begin
    addr_en = 1'b0;
    addr_d  = addr_q;
    unique case (state_q)
      ST_PTR:   begin addr_en = 1'b1; addr_d = upd_addr; end
      ST_INDEX: begin addr_en = 1'b1; addr_d = rf_rdata_i + disp_q; end
      ST_FPTR:  begin addr_en = mem_ack_i; addr_d = mem_rdata_i; end
      default: ;
    endcase
  end

  assign disp_en = (state_q == ST_FDISP) && mem_ack_i;

  always_comb begin
    opnd_en = 1'b0;
    opnd_d  = opnd_q;
    if (state_q == ST_REG) begin
      opnd_en = 1'b1;
      opnd_d  = rf_rdata_i;
    end else if ((state_q == ST_FOPND) && mem_ack_i) begin
      opnd_en = 1'b1;
      opnd_d  = mem_rdata_i;
    end
  end

  assign done_d = opnd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rn_q   <= '0;
    end else if (accept) begin
      mode_q <= spec_i[RW +: MODE_W];
      rn_q   <= spec_i[RW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       disp_q <= '0;
    else if (disp_en) disp_q <= mem_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       opnd_q <= '0;
    else if (opnd_en) opnd_q <= opnd_d;
  end
endmodule

// File: rtl/sos_chk.sv
module sos_chk #(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [DW-1:0] mem_addr_o,
  input logic          rf_we_o,
  input logic [RW-1:0] rf_waddr_o,
  input logic [2:0]    mode_q,
  input logic [RW-1:0] rn_q
);
  localparam logic [RW-1:0] PC_IDX = '1;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> mem_req_o); // R10
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> $stable(mem_addr_o)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R13
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rf_we_o); // R9
  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mode_q[2:1] == 2'b11 ? rf_waddr_o == PC_IDX : rf_waddr_o == rn_q)); // R9
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |=> !rf_we_o); // R9
  AST_MODE0_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == 3'd0) |-> (!mem_req_o && !rf_we_o)); // R1
  AST_MODE1_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == 3'd1) |-> !rf_we_o); // R2
  AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(mode_q) && $stable(rn_q))); // R12
endmodule

bind src_opnd_seq sos_chk #(.DW(DW), .RW($clog2(NREG))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .mode_q     (mode_q),
  .rn_q       (rn_q)
);

// File: tb/src_opnd_seq_tb.sv
module src_opnd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  spec_i = '0;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_ack;
  logic [15:0] mem_addr, mem_rdata;
  logic        busy, done;
  logic [15:0] opnd;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  src_opnd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .spec_i(spec_i),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .opnd_o(opnd)
  );

  // register file model with preload path
  logic [15:0] rf [8];
  logic [15:0] pl_vals [8];
  logic        pl_en = 1'b0;
  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) begin
    if (pl_en) rf <= pl_vals;
    else if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  // memory contents computed, word index = address bits [8:1]
  function automatic logic [15:0] mem_fn(input logic [15:0] a);
    logic [15:0] i;
    i = {8'h00, a[8:1]};
    return i * 16'h0136 + 16'h0044;
  endfunction

  // memory model with programmable latency and address-hold monitor
  int          mem_lat = 0;
  int          mcnt = 0;
  logic        ack_q = 1'b0;
  logic [15:0] rd_q = '0;
  logic [15:0] first_addr = '0;
  logic        in_req = 1'b0;
  int          addr_moves = 0;
  int          nreq = 0;
  assign mem_ack   = ack_q;
  assign mem_rdata = rd_q;
  always @(posedge clk) begin
    if (ack_q) begin
      ack_q  <= 1'b0;
      mcnt   <= 0;
      in_req <= 1'b0;
    end else if (mem_req) begin
      if (!in_req) begin
        in_req     <= 1'b1;
        first_addr <= mem_addr;
        nreq       <= nreq + 1;
      end else if (mem_addr != first_addr) begin
        addr_moves <= addr_moves + 1;
      end
      if (mcnt >= mem_lat) begin
        ack_q <= 1'b1;
        rd_q  <= mem_fn(mem_addr);
      end else begin
        mcnt <= mcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R4";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // {spec, named register value, pc value, latency}
  localparam logic [41:0] VEC [NV] = '{
    {6'o03, 16'h1234, 16'h0100, 4'd0},
    {6'o07, 16'h0104, 16'h0104, 4'd0},
    {6'o12, 16'h0040, 16'h0100, 4'd1},
    {6'o24, 16'h0050, 16'h0100, 4'd2},
    {6'o27, 16'h0120, 16'h0120, 4'd0},
    {6'o41, 16'h0060, 16'h0100, 4'd1},
    {6'o30, 16'h0070, 16'h0100, 4'd0},
    {6'o37, 16'h0130, 16'h0130, 4'd2},
    {6'o55, 16'h0080, 16'h0100, 4'd3},
    {6'o62, 16'h0090, 16'h0140, 4'd1},
    {6'o67, 16'h0150, 16'h0150, 4'd0},
    {6'o73, 16'h00A0, 16'h0160, 4'd2},
    {6'o77, 16'h0170, 16'h0170, 4'd4},
    {6'o46, 16'h0000, 16'h0100, 4'd0},
    {6'o21, 16'hFFFE, 16'h0100, 4'd1},
    {6'o60, 16'hFFF0, 16'h0180, 4'd0}
  };

  logic [15:0] exp_rf [8];
  logic [15:0] exp_op;

  task automatic model(input logic [5:0] sp);
    logic [2:0]  m, r;
    logic [15:0] p, d, a;
    m = sp[5:3];
    r = sp[2:0];
    exp_rf = pl_vals;
    case (m)
      3'd0: exp_op = exp_rf[r];
      3'd1: exp_op = mem_fn(exp_rf[r]);
      3'd2: begin exp_op = mem_fn(exp_rf[r]); exp_rf[r] = exp_rf[r] + 16'd2; end
      3'd3: begin p = mem_fn(exp_rf[r]); exp_rf[r] = exp_rf[r] + 16'd2; exp_op = mem_fn(p); end
      3'd4: begin exp_rf[r] = exp_rf[r] - 16'd2; exp_op = mem_fn(exp_rf[r]); end
      3'd5: begin exp_rf[r] = exp_rf[r] - 16'd2; exp_op = mem_fn(mem_fn(exp_rf[r])); end
      default: begin
        d = mem_fn(exp_rf[7]);
        exp_rf[7] = exp_rf[7] + 16'd2;
        a = exp_rf[r] + d;
        exp_op = (m == 3'd6) ? mem_fn(a) : mem_fn(mem_fn(a));
      end
    endcase
  endtask

  task automatic preload(input logic [2:0] r, input logic [15:0] rv, input logic [15:0] pc);
    for (int k = 0; k < 8; k++) pl_vals[k] = 16'h1100 + 16'(k * 4);
    pl_vals[7] = pc;
    pl_vals[r] = rv;
    @(negedge clk); pl_en = 1'b1;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic wait_done(output logic [15:0] got, output bit seen);
    int cnt;
    cnt = 0;
    while (!done && cnt < 100) begin @(negedge clk); cnt++; end
    seen = done;
    got = opnd;
  endtask

  task automatic check_rf(input logic [2:0] r, input string tag);
    for (int k = 0; k < 8; k++) begin
      if (k == int'(r) || k == 7) chk(rf[k] == exp_rf[k], tag, $sformatf("reg %0d", k), rf[k], exp_rf[k]);
      else                         chk(rf[k] == exp_rf[k], "R9", $sformatf("reg %0d", k), rf[k], exp_rf[k]);
    end
  endtask

  task automatic run_vec(input logic [41:0] v, input string wtag);
    logic [5:0]  sp;
    logic [15:0] got;
    bit          seen;
    int          moves0, nreq0;
    string       tag;
    sp = v[41:36];
    tag = (wtag != "") ? wtag : tag_of(sp[5:3]);
    preload(sp[2:0], v[35:20], v[19:4]);
    mem_lat = int'(v[3:0]);
    model(sp);
    moves0 = addr_moves;
    nreq0 = nreq;
    @(negedge clk); start_i = 1'b1; spec_i = sp;
    @(negedge clk); start_i = 1'b0;
    wait_done(got, seen);
    chk(seen, "R13", "done seen", 16'(seen), 16'd1);
    chk(got == exp_op, tag, "operand", got, exp_op);
    @(negedge clk);
    chk(!done, "R13", "done width", 16'(done), 16'd0);
    check_rf(sp[2:0], tag);
    chk(addr_moves == moves0, "R10", "address moved", 16'(addr_moves - moves0), 16'd0);
    if (sp[5:3] == 3'd0) chk(nreq == nreq0, "R1", "memory reads", 16'(nreq - nreq0), 16'd0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] got;
    bit          seen;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(!busy, "R13", "busy at reset", 16'(busy), 16'd0);
    chk(!done, "R13", "done at reset", 16'(done), 16'd0);
    chk(!mem_req, "R13", "req at reset", 16'(mem_req), 16'd0);
    chk(!rf_we, "R13", "we at reset", 16'(rf_we), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], (i >= 13) ? "R11" : "");
    end

    // R11: explicit wrap values
    preload(3'd6, 16'h0000, 16'h0100);
    mem_lat = 0;
    @(negedge clk); start_i = 1'b1; spec_i = 6'o46;
    @(negedge clk); start_i = 1'b0;
    wait_done(got, seen);
    @(negedge clk);
    chk(rf[6] == 16'hFFFE, "R11", "decrement wrap", rf[6], 16'hFFFE);
    preload(3'd1, 16'hFFFE, 16'h0100);
    @(negedge clk); start_i = 1'b1; spec_i = 6'o21;
    @(negedge clk); start_i = 1'b0;
    wait_done(got, seen);
    @(negedge clk);
    chk(rf[1] == 16'h0000, "R11", "increment wrap", rf[1], 16'h0000);

    // R12: start while busy is ignored
    preload(3'd5, 16'h0088, 16'h0100);
    mem_lat = 4;
    model(6'o55);
    @(negedge clk); start_i = 1'b1; spec_i = 6'o55;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); @(negedge clk);
    start_i = 1'b1; spec_i = 6'o01;
    @(negedge clk); start_i = 1'b0;
    wait_done(got, seen);
    chk(got == exp_op, "R12", "operand of first fetch", got, exp_op);
    @(negedge clk);
    repeat (3) begin
      chk(!busy && !done, "R12", "no second fetch", {14'd0, busy, done}, 16'd0);
      @(negedge clk);
    end
    check_rf(3'd5, "R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule